// File: doc/BRIEF.md
# Scaled Integer Add/Compare Unit

This unit is the integer add, subtract and compare slice of a 64-bit execution stage. Each cycle it can accept one operation, chosen by a 7-bit function code, on a first operand and a second operand. The second operand is either a 64-bit register value or an 8-bit literal padded with zeros. Results come out of a single output register one clock later.

Additions and subtractions work on 32-bit longwords or 64-bit quadwords. In the scaled forms the first operand is multiplied by 4 or 8 before use, which serves indexed address arithmetic. Longword results are sign-extended from bit 31 to fill the whole 64-bit result. Four of the codes are trapping variants: they give the same result as their base code and also raise a one-cycle overflow flag on signed overflow.

Compares give a 0/1 result. The byte compare gives an 8-bit mask, one bit for each byte lane of the operands. Register files, forwarding and the delivery of traps belong to the surrounding pipeline.

Top module: `int_scaled_alu`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock earlier. `result` and `ovf` belong to the operation accepted on that earlier edge. While `rst` is high at a clock edge, `out_valid`, `ovf` and `result` become 0.
- R2: Quadword add (code 0x20) gives the 64-bit sum modulo 2^64. Quadword subtract (code 0x29) gives A - B modulo 2^64.
- R3: Scaled codes shift A left by 2 or by 3 before the operation. Quadword: 0x22 gives 4A+B, 0x32 gives 8A+B, 0x2B gives 4A-B, 0x3B gives 8A-B. Longword: 0x02 gives 4A+B, 0x12 gives 8A+B, 0x0B gives 4A-B, 0x1B gives 8A-B.
- R4: Longword codes use only bits 31:0 of each operand. Code 0x00 adds and code 0x09 subtracts. The 32-bit result is sign-extended so that result bits 63:32 all equal bit 31.
- R5: The trapping codes 0x40 (longword add), 0x49 (longword subtract), 0x60 (quadword add) and 0x69 (quadword subtract) give the same result as their base code without bit 6. They set `ovf` when the signed result does not fit: in 32 bits for longwords, in 64 bits for quadwords.
- R6: Every code other than the four trapping codes leaves `ovf` at 0, even when the arithmetic overflows.
- R7: Compare codes put 1 or 0 in result bit 0 and clear bits 63:1. The codes are: 0x2D A==B, 0x4D signed A<B, 0x6D signed A<=B, 0x1D unsigned A<B, 0x3D unsigned A<=B.
- R8: Byte compare (code 0x0F) sets result bit i, for i from 0 to 7, when byte i of A is unsigned greater than or equal to byte i of B. Result bits 63:8 are 0.
- R9: When `lit_en` is 1, B is `lit` zero-extended to 64 bits and `opb` has no effect on the result.
- R10: Any other code produces a valid output with `result` 0 and `ovf` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| func | input | 7 | Function code |
| opa | input | 64 | First operand A |
| opb | input | 64 | Register form of second operand |
| lit_en | input | 1 | Use the literal as second operand |
| lit | input | 8 | 8-bit literal, zero-extended |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Result |
| ovf | output | 1 | Overflow from a trapping code, valid with `out_valid` |

## Verification
Every output of this unit is due on the first rising edge after the operation is accepted. `result`, `ovf` and `out_valid` become visible together after that edge, with no extra stage for any code. The bench applies a new operation at each falling edge. At the next falling edge it compares all three outputs with a behavioural model, so back-to-back operations are checked every clock. A cycle with `in_valid` low is checked the same way, for `out_valid` low one clock later.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam logic [6:0] FN_ADDL    = 7'h00;
    localparam logic [6:0] FN_S4ADDL  = 7'h02;
    localparam logic [6:0] FN_S8ADDL  = 7'h12;
    localparam logic [6:0] FN_SUBL    = 7'h09;
    localparam logic [6:0] FN_S4SUBL  = 7'h0B;
    localparam logic [6:0] FN_S8SUBL  = 7'h1B;
    localparam logic [6:0] FN_ADDQ    = 7'h20;
    localparam logic [6:0] FN_S4ADDQ  = 7'h22;
    localparam logic [6:0] FN_S8ADDQ  = 7'h32;
    localparam logic [6:0] FN_SUBQ    = 7'h29;
    localparam logic [6:0] FN_S4SUBQ  = 7'h2B;
    localparam logic [6:0] FN_S8SUBQ  = 7'h3B;
    localparam logic [6:0] FN_ADDL_V  = 7'h40;
    localparam logic [6:0] FN_SUBL_V  = 7'h49;
    localparam logic [6:0] FN_ADDQ_V  = 7'h60;
    localparam logic [6:0] FN_SUBQ_V  = 7'h69;
    localparam logic [6:0] FN_CMPEQ   = 7'h2D;
    localparam logic [6:0] FN_CMPLT   = 7'h4D;
    localparam logic [6:0] FN_CMPLE   = 7'h6D;
    localparam logic [6:0] FN_CMPULT  = 7'h1D;
    localparam logic [6:0] FN_CMPULE  = 7'h3D;
    localparam logic [6:0] FN_BYTEGE  = 7'h0F;

    typedef enum logic [1:0] {
        CL_NONE  = 2'd0,
        CL_ARITH = 2'd1,
        CL_CMP   = 2'd2,
        CL_BYTE  = 2'd3
    } op_class_e;

    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_SLT = 3'd1,
        CMP_SLE = 3'd2,
        CMP_ULT = 3'd3,
        CMP_ULE = 3'd4
    } cmp_sel_e;

    typedef struct packed {
        op_class_e  cls;
        cmp_sel_e   cmp;
        logic       sub;
        logic       is_long;
        logic [1:0] shamt;
        logic       trap;
    } op_dec_t;

    function automatic op_dec_t decode_func(input logic [6:0] f);
        op_dec_t d;
        d.cls     = CL_NONE;
        d.cmp     = CMP_EQ;
        d.sub     = 1'b0;
        d.is_long = 1'b0;
        d.shamt   = 2'd0;
        d.trap    = 1'b0;
        case (f)
            FN_ADDL:   begin d.cls = CL_ARITH; d.is_long = 1'b1; end
            FN_S4ADDL: begin d.cls = CL_ARITH; d.is_long = 1'b1; d.shamt = 2'd2; end
            FN_S8ADDL: begin d.cls = CL_ARITH; d.is_long = 1'b1; d.shamt = 2'd3; end
            FN_SUBL:   begin d.cls = CL_ARITH; d.is_long = 1'b1; d.sub = 1'b1; end
            FN_S4SUBL: begin d.cls = CL_ARITH; d.is_long = 1'b1; d.sub = 1'b1; d.shamt = 2'd2; end
            FN_S8SUBL: begin d.cls = CL_ARITH; d.is_long = 1'b1; d.sub = 1'b1; d.shamt = 2'd3; end
            FN_ADDQ:   begin d.cls = CL_ARITH; end
            FN_S4ADDQ: begin d.cls = CL_ARITH; d.shamt = 2'd2; end
            FN_S8ADDQ: begin d.cls = CL_ARITH; d.shamt = 2'd3; end
            FN_SUBQ:   begin d.cls = CL_ARITH; d.sub = 1'b1; end
            FN_S4SUBQ: begin d.cls = CL_ARITH; d.sub = 1'b1; d.shamt = 2'd2; end
            FN_S8SUBQ: begin d.cls = CL_ARITH; d.sub = 1'b1; d.shamt = 2'd3; end
            FN_ADDL_V: begin d.cls = CL_ARITH; d.is_long = 1'b1; d.trap = 1'b1; end
            FN_SUBL_V: begin d.cls = CL_ARITH; d.is_long = 1'b1; d.sub = 1'b1; d.trap = 1'b1; end
            FN_ADDQ_V: begin d.cls = CL_ARITH; d.trap = 1'b1; end
            FN_SUBQ_V: begin d.cls = CL_ARITH; d.sub = 1'b1; d.trap = 1'b1; end
            FN_CMPEQ:  begin d.cls = CL_CMP; d.cmp = CMP_EQ;  end
            FN_CMPLT:  begin d.cls = CL_CMP; d.cmp = CMP_SLT; end
            FN_CMPLE:  begin d.cls = CL_CMP; d.cmp = CMP_SLE; end
            FN_CMPULT: begin d.cls = CL_CMP; d.cmp = CMP_ULT; end
            FN_CMPULE: begin d.cls = CL_CMP; d.cmp = CMP_ULE; end
            FN_BYTEGE: begin d.cls = CL_BYTE; end
            default:   begin d.cls = CL_NONE; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    input  logic              is_long,
    input  logic [1:0]        shamt,
    output logic [DATA_W-1:0] res,
    output logic              ovf_raw
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] a_sc;
    logic [DATA_W-1:0] full;
    logic [HALF_W-1:0] low;
    logic              sgn_a, sgn_b, sgn_r;

    always_comb begin
        a_sc = a << shamt;
        full = sub ? (a_sc - b) : (a_sc + b);
        low  = full[HALF_W-1:0];
        res  = is_long ? {{(DATA_W-HALF_W){low[HALF_W-1]}}, low} : full;

        // sign bits at the width of the operation
        sgn_a = is_long ? a_sc[HALF_W-1] : a_sc[DATA_W-1];
        sgn_b = is_long ? b[HALF_W-1]    : b[DATA_W-1];
        sgn_r = is_long ? low[HALF_W-1]  : full[DATA_W-1];

        if (sub) ovf_raw = (sgn_a != sgn_b) && (sgn_r != sgn_a);
        else     ovf_raw = (sgn_a == sgn_b) && (sgn_r != sgn_a);
    end

endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  alu_pkg::cmp_sel_e  sel,
    output logic               hit
);
    import alu_pkg::*;

    logic eq, slt, ult;

    always_comb begin
        eq  = (a == b);
        slt = ($signed(a) < $signed(b));
        ult = (a < b);
        case (sel)
            CMP_EQ:  hit = eq;
            CMP_SLT: hit = slt;
            CMP_SLE: hit = slt | eq;
            CMP_ULT: hit = ult;
            CMP_ULE: hit = ult | eq;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_bytecmp.sv
module alu_bytecmp #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [LANES-1:0]  mask
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign mask[i] = (a[i*LANE_W +: LANE_W] >= b[i*LANE_W +: LANE_W]);
    end

endmodule

// File: rtl/int_scaled_alu.sv
module int_scaled_alu #(
    parameter int DATA_W = 64,
    parameter int LIT_W  = 8,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [6:0]        func,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              lit_en,
    input  logic [LIT_W-1:0]  lit,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              ovf
);
    import alu_pkg::*;

    localparam int LANES  = DATA_W / LANE_W;
    localparam int HALF_W = DATA_W / 2;

    op_dec_t           dec;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] arith_res;
    logic              arith_ovf;
    logic              cmp_hit;
    logic [LANES-1:0]  byte_mask;
    logic [DATA_W-1:0] res_nxt;

    always_comb begin
        dec   = decode_func(func);
        b_eff = lit_en ? {{(DATA_W-LIT_W){1'b0}}, lit} : opb;
    end

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a       (opa),
        .b       (b_eff),
        .sub     (dec.sub),
        .is_long (dec.is_long),
        .shamt   (dec.shamt),
        .res     (arith_res),
        .ovf_raw (arith_ovf)
    );

    alu_cmp #(.DATA_W(DATA_W)) u_cmp (
        .a   (opa),
        .b   (b_eff),
        .sel (dec.cmp),
        .hit (cmp_hit)
    );

    alu_bytecmp #(.DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES)) u_bytecmp (
        .a    (opa),
        .b    (b_eff),
        .mask (byte_mask)
    );

    always_comb begin
        case (dec.cls)
            CL_ARITH: res_nxt = arith_res;
            CL_CMP:   res_nxt = {{(DATA_W-1){1'b0}}, cmp_hit};
            CL_BYTE:  res_nxt = {{(DATA_W-LANES){1'b0}}, byte_mask};
            default:  res_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            ovf       <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            ovf       <= in_valid & dec.trap & arith_ovf;
            if (in_valid) result <= res_nxt;
        end
    end

    // R1: output valid tracks the input one clock later
    a_r1_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle_follow: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6: only trapping codes can flag overflow
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec.trap) |=> !ovf);

    // R4: longword results are sign-extended
    a_r4_sext: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.cls == CL_ARITH && dec.is_long)
        |=> (result[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){result[HALF_W-1]}}));

    // R7: compares give 0 or 1
    a_r7_bool: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.cls == CL_CMP) |=> (result[DATA_W-1:1] == '0));

    // R8: byte compare leaves upper bits clear
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.cls == CL_BYTE) |=> (result[DATA_W-1:LANES] == '0));

    // R10: unknown codes give zero and no overflow
    a_r10_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dec.cls == CL_NONE) |=> (result == '0 && !ovf));

endmodule

// File: tb/test_int_scaled_alu.sv
`timescale 1ns/1ps
module test_int_scaled_alu;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [6:0]  func;
    logic [63:0] opa, opb;
    logic        lit_en;
    logic [7:0]  lit;
    logic        out_valid;
    logic [63:0] result;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    int_scaled_alu i_int_scaled_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
        .opa(opa), .opb(opb), .lit_en(lit_en), .lit(lit),
        .out_valid(out_valid), .result(result), .ovf(ovf)
    );

    // behavioural reference
    task automatic model(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic o);
        int sh;
        bit is_arith, is_long, is_sub, trap;
        logic [63:0] as;
        logic signed [64:0] wq;
        logic signed [32:0] wl;
        r = 64'd0; o = 1'b0;
        sh = 0; is_arith = 0; is_long = 0; is_sub = 0; trap = 0;
        if (f inside {7'h02, 7'h0B, 7'h22, 7'h2B}) sh = 2;
        if (f inside {7'h12, 7'h1B, 7'h32, 7'h3B}) sh = 3;
        if (f inside {7'h00, 7'h02, 7'h12, 7'h40}) begin is_arith = 1; is_long = 1; end
        if (f inside {7'h09, 7'h0B, 7'h1B, 7'h49}) begin is_arith = 1; is_long = 1; is_sub = 1; end
        if (f inside {7'h20, 7'h22, 7'h32, 7'h60}) begin is_arith = 1; end
        if (f inside {7'h29, 7'h2B, 7'h3B, 7'h69}) begin is_arith = 1; is_sub = 1; end
        trap = f inside {7'h40, 7'h49, 7'h60, 7'h69};
        as = a * (64'd1 << sh);
        if (is_arith) begin
            if (is_long) begin
                wl = is_sub ? ($signed({as[31], as[31:0]}) - $signed({b[31], b[31:0]}))
                            : ($signed({as[31], as[31:0]}) + $signed({b[31], b[31:0]}));
                r = {{32{wl[31]}}, wl[31:0]};
                o = trap && (wl[32] != wl[31]);
            end else begin
                wq = is_sub ? ($signed({as[63], as}) - $signed({b[63], b}))
                            : ($signed({as[63], as}) + $signed({b[63], b}));
                r = wq[63:0];
                o = trap && (wq[64] != wq[63]);
            end
        end else begin
            case (f)
                7'h2D: r = {63'd0, a == b};
                7'h4D: r = {63'd0, $signed(a) <  $signed(b)};
                7'h6D: r = {63'd0, $signed(a) <= $signed(b)};
                7'h1D: r = {63'd0, a <  b};
                7'h3D: r = {63'd0, a <= b};
                7'h0F: for (int i = 0; i < 8; i++) r[i] = (a[8*i +: 8] >= b[8*i +: 8]);
                default: r = 64'd0;
            endcase
        end
    endtask

    task automatic check(input string tag, input logic v_e, input logic [63:0] r_e, input logic o_e);
        checks++;
        if (out_valid !== v_e || ovf !== o_e || (v_e && result !== r_e)) begin
            errors++;
            $display("FAIL %s: got valid=%0b ovf=%0b result=%h, expected valid=%0b ovf=%0b result=%h",
                     tag, out_valid, ovf, result, v_e, o_e, r_e);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic op(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                      input logic le, input logic [7:0] l, input string tag);
        logic [63:0] r_e;
        logic        o_e;
        model(f, a, le ? {56'd0, l} : b, r_e, o_e);
        in_valid = 1'b1; func = f; opa = a; opb = b; lit_en = le; lit = l;
        @(negedge clk);
        check(tag, 1'b1, r_e, o_e);
    endtask

    task automatic idle(input string tag);
        in_valid = 1'b0; func = 7'h7F; opa = '1; opb = '1; lit_en = 1'b0; lit = 8'hFF;
        @(negedge clk);
        check(tag, 1'b0, 64'd0, 1'b0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; func = 7'h00; opa = '0; opb = '0; lit_en = 1'b0; lit = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 64'd0, 1'b0);
        if (result !== 64'd0) begin checks++; errors++;
            $display("FAIL R1 reset result: got %h expected 0", result); end
        else checks++;
        rst = 1'b0;

        // R2 quadword add/sub
        op(7'h20, 64'h0000_0001_0000_0005, 64'h0000_0000_FFFF_FFFF, 0, 0, "R2 addq");
        op(7'h20, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 0, 0, "R2 addq wrap");
        op(7'h29, 64'h5, 64'h7, 0, 0, "R2 subq negative");
        // R3 scaled forms
        op(7'h22, 64'h100, 64'h3, 0, 0, "R3 s4addq");
        op(7'h32, 64'h100, 64'h3, 0, 0, "R3 s8addq");
        op(7'h2B, 64'h100, 64'h3, 0, 0, "R3 s4subq");
        op(7'h3B, 64'h1, 64'h10, 0, 0, "R3 s8subq");
        op(7'h02, 64'hAAAA_0000_2000_0000, 64'h1, 0, 0, "R3 s4addl");
        op(7'h12, 64'h0000_0000_1000_0001, 64'h0, 0, 0, "R3 s8addl");
        op(7'h0B, 64'h3, 64'h20, 0, 0, "R3 s4subl");
        op(7'h1B, 64'h4, 64'h1, 0, 0, "R3 s8subl");
        // R4 longword with upper bits ignored and sign extension
        op(7'h00, 64'h1234_5678_7FFF_FFFF, 64'hDEAD_BEEF_0000_0001, 0, 0, "R4 addl sext");
        op(7'h09, 64'hFFFF_0000_0000_0003, 64'h0000_FFFF_0000_0005, 0, 0, "R4 subl");
        // R5 trapping forms
        op(7'h40, 64'h7FFF_FFFF, 64'h1, 0, 0, "R5 addl/v overflow");
        op(7'h40, 64'h7FFF_FFFE, 64'h1, 0, 0, "R5 addl/v no overflow");
        op(7'h49, 64'h8000_0000, 64'h1, 0, 0, "R5 subl/v overflow");
        op(7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, "R5 addq/v overflow");
        op(7'h69, 64'h8000_0000_0000_0000, 64'h1, 0, 0, "R5 subq/v overflow");
        op(7'h69, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0, "R5 subq/v same sign");
        op(7'h60, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R5 addq/v negative overflow");
        // R6 non-trapping overflow stays quiet
        op(7'h20, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, "R6 addq no flag");
        op(7'h00, 64'h7FFF_FFFF, 64'h1, 0, 0, "R6 addl no flag");
        op(7'h32, 64'h1000_0000_0000_0000, 64'h0, 0, 0, "R6 s8addq no flag");
        // R7 compares
        op(7'h2D, 64'h55, 64'h55, 0, 0, "R7 cmpeq true");
        op(7'h2D, 64'h55, 64'h56, 0, 0, "R7 cmpeq false");
        op(7'h4D, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, "R7 signed lt");
        op(7'h1D, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, "R7 unsigned lt");
        op(7'h6D, 64'h7, 64'h7, 0, 0, "R7 signed le equal");
        op(7'h3D, 64'h8, 64'h7, 0, 0, "R7 unsigned le false");
        op(7'h3D, 64'h1, 64'h8000_0000_0000_0000, 0, 0, "R7 unsigned le true");
        // R8 byte compare
        op(7'h0F, 64'h00FF_1080_7F01_0203, 64'h0100_1081_7E01_0302, 0, 0, "R8 byte ge");
        op(7'h0F, 64'h0, 64'h0, 0, 0, "R8 byte all equal");
        // R9 literal operand
        op(7'h20, 64'h1000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 8'hFF, "R9 literal add");
        op(7'h0F, 64'h0000_0000_0000_0080, 64'h0, 1, 8'h81, "R9 literal byte cmp");
        op(7'h2D, 64'h42, 64'h1234, 1, 8'h42, "R9 literal cmpeq");
        // R10 unknown codes
        op(7'h7F, 64'h1234, 64'h5678, 0, 0, "R10 unknown 0x7f");
        op(7'h01, 64'h1234, 64'h5678, 0, 0, "R10 unknown 0x01");
        // R1 idle cycle and back to back
        idle("R1 idle");
        op(7'h60, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, "R1 after idle");
        idle("R1 ovf single cycle");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got no completion, expected end of test");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule